// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block watches six external interrupt request pins and latches a status flag for each pin when the configured edge arrives. Each pin is first brought into the clock domain through a two-stage synchroniser, then compared with its previous synchronised sample to find edges. A per-pin select picks rising or falling detection. Pin 0 alone can also be set to react to either edge.

Flags are cleared in two ways. Software must first read the status register while a flag is 1 and then write a 0 to that bit. Hardware clears a flag when the processor signals, through a per-source acknowledge input, that it has entered the exception for that source. A small byte-wide register port gives access to the status register and to an 8-bit level register. The level register marks each source as normal or elevated. Two request outputs combine the enabled flags: one for any source, and one for elevated sources only.

Top module: `irqf_ctrl`

## Requirements
- R1: After reset all six flags are 0, the status and level registers read 0x00, and both request outputs are 0.
- R2: With a pin's select at 0 (falling), a 1-to-0 transition on that pin sets its flag, and a 0-to-1 transition does not.
- R3: With a pin's select at 1 (rising), a 0-to-1 transition sets its flag, and a 1-to-0 transition does not.
- R4: When `pin0_both` is 1, either transition on pin 0 sets flag 0. `pin0_both` has no effect on pins 1 to 5.
- R5: Writing 1 to a status bit leaves that flag unchanged. Status bits 7 and 6 always read 0, and bits 5..0 read flags 5..0.
- R6: A status write of 0 to bit n clears flag n only if a status read since the last status write returned bit n as 1.
- R7: Any status write discards all remembered read-as-1 marks, so a later write of 0 without a new read clears nothing.
- R8: A one-cycle pulse on `irq_ack[n]` clears flag n.
- R9: An edge event that arrives in the same cycle as an acknowledge or a software clear of the same flag leaves the flag set.
- R10: The level register (address 1) is read/write. `irq_req` is 1 when any flag with its `src_en` bit set is 1. `irq_req_pri` is 1 when any such flag also has its level bit set to 1.
- R11: A pin change made before clock edge k is seen in the flag after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 6 | Asynchronous interrupt request pins |
| edge_rise | input | 6 | Per-pin edge select: 1 rising, 0 falling |
| pin0_both | input | 1 | Pin 0 reacts to both edges when 1 |
| irq_ack | input | 6 | Per-source exception acknowledge pulse |
| src_en | input | 6 | Per-source request enable |
| bus_addr | input | 1 | Register select: 0 status, 1 level |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after the read strobe |
| irq_flags | output | 6 | Current flag vector |
| irq_req | output | 1 | Any enabled flag set |
| irq_req_pri | output | 1 | Any enabled flag with elevated level set |

## Verification
An edge event on a pin can land in the same clock cycle as a clear of that pin's flag. The clear can come from the acknowledge input or from an armed software write of 0. The bench provokes this by counting clock edges from the pin change: it asserts the acknowledge, or issues the status write, exactly in the cycle after the second synchroniser stage takes the new level. It then expects the flag still set. A clear with no edge in that cycle is checked separately and must take the flag back to 0.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int NSRC_DEF  = 6;
    localparam int DW_DEF    = 8;
    localparam int SYNC_DEF  = 2;

    typedef enum logic {
        REG_STAT = 1'b0,
        REG_LVL  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        reg_sel_e           sel;
        logic [DW_DEF-1:0]  data;
    } bus_req_t;

    // Edge decision for one pin: any change when both edges are allowed,
    // otherwise the new level must match the selected direction.
    function automatic logic edge_hit(input logic cur, input logic prev,
                                      input logic rise, input logic both);
        if (cur == prev) return 1'b0;
        if (both)        return 1'b1;
        return (cur == rise);
    endfunction

endpackage

// File: rtl/irqf_edge.sv
module irqf_edge
    import irqf_pkg::*;
#(
    parameter int              NSRC      = NSRC_DEF,
    parameter int              SYNC      = SYNC_DEF,
    parameter logic [NSRC-1:0] BOTH_MASK = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pin,
    input  logic [NSRC-1:0] rise_sel,
    input  logic            both_sel,
    output logic [NSRC-1:0] edge_evt
);

    for (genvar i = 0; i < NSRC; i++) begin : g_pin
        logic [SYNC-1:0] stg;
        logic            prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                stg  <= '0;
                prev <= 1'b0;
            end else begin
                stg  <= {stg[SYNC-2:0], pin[i]};
                prev <= stg[SYNC-1];
            end
        end

        if (BOTH_MASK[i]) begin : g_both
            assign edge_evt[i] = edge_hit(stg[SYNC-1], prev, rise_sel[i], both_sel);
        end else begin : g_single
            assign edge_evt[i] = edge_hit(stg[SYNC-1], prev, rise_sel[i], 1'b0);

            // R4
            single_dir_chk: assert property (@(posedge clk) disable iff (rst)
                edge_evt[i] |-> (stg[SYNC-1] == rise_sel[i]));
        end
    end

endmodule

// File: rtl/irqf_flags.sv
module irqf_flags
    import irqf_pkg::*;
#(
    parameter int NSRC = NSRC_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] edge_evt,
    input  logic [NSRC-1:0] ack,
    input  logic            stat_rd,
    input  logic            stat_wr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] flags
);

    logic [NSRC-1:0] armed;
    logic [NSRC-1:0] sw_clr;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] flags_n;
    logic [NSRC-1:0] armed_n;

    always_comb begin
        sw_clr  = stat_wr ? (armed & ~wdata) : '0;
        clr     = sw_clr | ack;
        flags_n = (flags & ~clr) | edge_evt;
        if (stat_wr)      armed_n = '0;
        else if (stat_rd) armed_n = armed | flags;
        else              armed_n = armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            armed <= '0;
        end else begin
            flags <= flags_n;
            armed <= armed_n;
        end
    end

    // R5
    wr_one_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((flags & $past(flags) & $past(wdata)) == ($past(flags) & $past(wdata))));

    // R6
    clear_needs_cause_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(flags) & ~flags) &
                   ~($past(ack) | ($past(armed) & ~$past(wdata) & {NSRC{$past(stat_wr)}}))) == '0));

    // R7
    arm_drop_chk: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> (armed == '0));

    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|edge_evt) |=> ((flags & $past(edge_evt)) == $past(edge_evt)));

endmodule

// File: rtl/irqf_bus.sv
module irqf_bus
    import irqf_pkg::*;
#(
    parameter int NSRC = NSRC_DEF,
    parameter int DW   = DW_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    input  logic [NSRC-1:0] flags,
    output logic            stat_rd,
    output logic            stat_wr,
    output logic [NSRC-1:0] wdata_lo,
    output logic [DW-1:0]   level,
    output logic [DW-1:0]   rdata
);

    localparam int PAD = DW - NSRC;

    logic [DW-1:0] rd_val;

    assign stat_rd  = req.rd && (req.sel == REG_STAT);
    assign stat_wr  = req.wr && (req.sel == REG_STAT);
    assign wdata_lo = req.data[NSRC-1:0];

    always_comb begin
        if (req.sel == REG_STAT) rd_val = {{PAD{1'b0}}, flags};
        else                     rd_val = level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            rdata <= '0;
        end else begin
            if (req.wr && (req.sel == REG_LVL)) level <= req.data;
            if (req.rd)                         rdata <= rd_val;
        end
    end

    // R5
    stat_pad_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (rdata[DW-1:NSRC] == '0));

endmodule

// File: rtl/irqf_ctrl.sv
module irqf_ctrl
    import irqf_pkg::*;
#(
    parameter int              NSRC      = NSRC_DEF,
    parameter int              SYNC      = SYNC_DEF,
    parameter logic [NSRC-1:0] BOTH_MASK = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_pin,
    input  logic [NSRC-1:0] edge_rise,
    input  logic            pin0_both,
    input  logic [NSRC-1:0] irq_ack,
    input  logic [NSRC-1:0] src_en,
    input  logic            bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    output logic [NSRC-1:0] irq_flags,
    output logic            irq_req,
    output logic            irq_req_pri
);

    bus_req_t        req;
    logic [NSRC-1:0] edge_evt;
    logic            stat_rd;
    logic            stat_wr;
    logic [NSRC-1:0] wdata_lo;
    logic [7:0]      level;
    logic [NSRC-1:0] live;

    assign req.wr   = bus_wr;
    assign req.rd   = bus_rd;
    assign req.sel  = reg_sel_e'(bus_addr);
    assign req.data = bus_wdata;

    irqf_edge #(.NSRC(NSRC), .SYNC(SYNC), .BOTH_MASK(BOTH_MASK)) u_edge (
        .clk(clk), .rst(rst), .pin(irq_pin), .rise_sel(edge_rise),
        .both_sel(pin0_both), .edge_evt(edge_evt)
    );

    irqf_flags #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst(rst), .edge_evt(edge_evt), .ack(irq_ack),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .wdata(wdata_lo), .flags(irq_flags)
    );

    irqf_bus #(.NSRC(NSRC), .DW(8)) u_bus (
        .clk(clk), .rst(rst), .req(req), .flags(irq_flags),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .wdata_lo(wdata_lo),
        .level(level), .rdata(bus_rdata)
    );

    assign live        = irq_flags & src_en;
    assign irq_req     = |live;
    assign irq_req_pri = |(live & level[NSRC-1:0]);

    // R10
    pri_implies_req_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req_pri |-> irq_req);

endmodule

// File: tb/irqf_ctrl_test.sv
module irqf_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] irq_pin = '0;
    logic [5:0] edge_rise = '0;
    logic       pin0_both = 1'b0;
    logic [5:0] irq_ack = '0;
    logic [5:0] src_en = '0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] irq_flags;
    logic       irq_req;
    logic       irq_req_pri;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    irqf_ctrl uut (
        .clk(clk), .rst(rst), .irq_pin(irq_pin), .edge_rise(edge_rise),
        .pin0_both(pin0_both), .irq_ack(irq_ack), .src_en(src_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_flags(irq_flags),
        .irq_req(irq_req), .irq_req_pri(irq_req_pri)
    );

    // {pins before, pins after, edge select, both flag, expected flags}
    localparam logic [24:0] VEC [10] = '{
        {6'h00, 6'h3F, 6'h3F, 1'b0, 6'h3F},
        {6'h3F, 6'h00, 6'h00, 1'b0, 6'h3F},
        {6'h00, 6'h3F, 6'h00, 1'b0, 6'h00},
        {6'h3F, 6'h00, 6'h3F, 1'b0, 6'h00},
        {6'h00, 6'h01, 6'h00, 1'b1, 6'h01},
        {6'h01, 6'h00, 6'h01, 1'b1, 6'h01},
        {6'h00, 6'h2A, 6'h2A, 1'b0, 6'h2A},
        {6'h15, 6'h00, 6'h00, 1'b0, 6'h15},
        {6'h3E, 6'h00, 6'h00, 1'b1, 6'h3E},
        {6'h00, 6'h3E, 6'h00, 1'b1, 6'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ack_pulse(input logic [5:0] m);
        irq_ack = m;
        @(negedge clk);
        irq_ack = '0;
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // R1 reset state
        chk("R1 flags", {2'b0, irq_flags}, 8'h00);
        chk("R1 req", {6'b0, irq_req, irq_req_pri}, 8'h00);
        bus_read(1'b0, rd); chk("R1 status", rd, 8'h00);
        bus_read(1'b1, rd); chk("R1 level", rd, 8'h00);

        // R2 R3 R4 vector table
        for (int k = 0; k < 10; k++) begin
            edge_rise = VEC[k][12:7];
            pin0_both = VEC[k][6];
            irq_pin   = VEC[k][24:19];
            wait_n(4);
            ack_pulse(6'h3F);
            irq_pin = VEC[k][18:13];
            wait_n(4);
            chk($sformatf("R2/R3/R4 vec%0d", k), {2'b0, irq_flags}, {2'b0, VEC[k][5:0]});
        end
        ack_pulse(6'h3F);
        pin0_both = 1'b0;
        edge_rise = 6'h3F;
        irq_pin = 6'h00;
        wait_n(4);
        chk("R3 falls ignored", {2'b0, irq_flags}, 8'h00);

        // R11 latency
        irq_pin = 6'h01;
        wait_n(2);
        chk("R11 before", {2'b0, irq_flags}, 8'h00);
        wait_n(1);
        chk("R11 after", {2'b0, irq_flags}, 8'h01);

        irq_pin = 6'h3F;
        wait_n(4);
        chk("R3 all set", {2'b0, irq_flags}, 8'h3F);

        // R5 write ones, padding bits
        bus_write(1'b0, 8'hFF);
        chk("R5 write ones", {2'b0, irq_flags}, 8'h3F);
        bus_read(1'b0, rd);
        chk("R5 readback", rd, 8'h3F);

        // R7 any write discards marks
        bus_write(1'b0, 8'hFF);
        bus_write(1'b0, 8'h00);
        chk("R7 marks dropped", {2'b0, irq_flags}, 8'h3F);

        // R6 read then write zero to one bit
        bus_read(1'b0, rd);
        bus_write(1'b0, 8'h3E);
        chk("R6 clear bit0", {2'b0, irq_flags}, 8'h3E);
        bus_write(1'b0, 8'h00);
        chk("R6 no read no clear", {2'b0, irq_flags}, 8'h3E);

        // R6 only bits read as 1 are armed
        bus_read(1'b0, rd);
        chk("R6 read 3E", rd, 8'h3E);
        irq_pin = 6'h3E; wait_n(4);
        irq_pin = 6'h3F; wait_n(4);
        bus_write(1'b0, 8'h00);
        chk("R6 partial arm", {2'b0, irq_flags}, 8'h01);

        // R8 acknowledge
        ack_pulse(6'h01);
        chk("R8 ack clears", {2'b0, irq_flags}, 8'h00);

        // R10 level register and requests
        bus_write(1'b1, 8'hC4);
        bus_read(1'b1, rd);
        chk("R10 level rw", rd, 8'hC4);
        edge_rise = 6'h00;
        irq_pin = 6'h39;
        wait_n(4);
        chk("R2 flags 06", {2'b0, irq_flags}, 8'h06);
        src_en = 6'h00; wait_n(1);
        chk("R10 none en", {6'b0, irq_req, irq_req_pri}, 8'h00);
        src_en = 6'h02; wait_n(1);
        chk("R10 normal", {6'b0, irq_req, irq_req_pri}, 8'h02);
        src_en = 6'h04; wait_n(1);
        chk("R10 elevated", {6'b0, irq_req, irq_req_pri}, 8'h03);
        src_en = 6'h00;
        ack_pulse(6'h3F);

        // R9 edge and acknowledge in the same cycle
        irq_pin = 6'h38; wait_n(4);
        chk("R2 pin0 fall", {2'b0, irq_flags}, 8'h01);
        irq_pin = 6'h39; wait_n(4);
        irq_pin = 6'h38;
        wait_n(2);
        irq_ack = 6'h01;
        wait_n(1);
        irq_ack = 6'h00;
        chk("R9 edge beats ack", {2'b0, irq_flags}, 8'h01);
        ack_pulse(6'h01);
        chk("R8 ack alone", {2'b0, irq_flags}, 8'h00);

        // R9 edge and software clear in the same cycle
        irq_pin = 6'h39; wait_n(4);
        irq_pin = 6'h38; wait_n(4);
        bus_read(1'b0, rd);
        chk("R5 read 01", rd, 8'h01);
        irq_pin = 6'h39; wait_n(4);
        irq_pin = 6'h38;
        wait_n(2);
        bus_write(1'b0, 8'h00);
        chk("R9 edge beats write", {2'b0, irq_flags}, 8'h01);
        bus_write(1'b0, 8'h00);
        chk("R7 second write", {2'b0, irq_flags}, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule